// File: doc/BRIEF.md
# Packed Nibble Tag Comparator

The block checks a run of 4-bit allocation tags against one reference tag. A tag store supplies the tags packed two to a byte. A start pulse loads three values: the reference tag, a flag that says whether the first tag sits in the upper half of the first byte, and the number of tags to test. The block then pulls tag bytes over a valid/ready stream and tests one nibble per cycle. It does this in order.

The scan stops at the first tag that differs from the reference, or once the requested number of tags has matched. A one-cycle done pulse then presents two results: the number of tags that matched before the stop, and a pass flag. Pass is set when that number equals the requested count. The block stops requesting bytes as soon as it stops testing. A caller that needs the position of a failing tag reads it directly from the match count.

Top module: `nibble_tag_scan`

## Requirements
- R1: After reset the block is idle: `busy_o`, `byte_ready_o` and `done_o` are all low.
- R2: Within a tag byte, bits [3:0] hold the even-numbered tag and bits [7:4] hold the odd-numbered tag. The lower nibble is tested before the upper nibble.
- R3: A tag mismatches when it is not equal to the reference tag. The scan stops at the first mismatching tag, and `match_cnt_o` equals the number of tags tested before it.
- R4: When `odd_i` is 1 at start, the lower nibble of the first byte is skipped and has no effect on the result. Testing begins at that byte's upper nibble.
- R5: If no mismatch occurs, the scan stops once `count_i` tags have matched. `match_cnt_o` then equals `count_i`, and no tag beyond the count is tested.
- R6: `pass_o` is 1 exactly when `match_cnt_o` equals the requested count.
- R7: A start with `count_i` = 0 raises `done_o` on the next cycle with `match_cnt_o` = 0 and `pass_o` = 1. It consumes no byte.
- R8: The block fetches a new byte only at the start of a scan, or after both nibbles of the current byte have been tested or skipped. `byte_ready_o` is low from the cycle that `done_o` is high until the next start. The number of bytes accepted is therefore floor((odd + tested − 1)/2) + 1, where tested is the number of nibbles compared.
- R9: `done_o` is a single-cycle pulse per scan, and `match_cnt_o` and `pass_o` are valid while it is high.
- R10: `start_i` is ignored while `busy_o` is high. The running scan's parameters and result are unaffected.
- R11: While `byte_valid_i` is low during a fetch, the scan holds its position. The result does not depend on stall timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| ref_tag_i | input | TAG_W | Reference tag |
| odd_i | input | 1 | Begin at the upper nibble of the first byte |
| count_i | input | CNT_W | Number of tags to test |
| byte_i | input | 2*TAG_W | Packed tag byte |
| byte_valid_i | input | 1 | Tag byte valid |
| byte_ready_o | output | 1 | Block accepts a tag byte |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| match_cnt_o | output | CNT_W | Number of leading matching tags |
| pass_o | output | 1 | All requested tags matched |

## Verification
The bench builds the block with its defaults, TAG_W = 4 and CNT_W = 4. These defaults let the sweep reach every count from 0 to 15, with either start parity and every mismatch position, including no mismatch. Each scan places a mismatching nibble just past the count, and the skipped nibble for an odd start also mismatches. A result that is correct therefore also shows that neither nibble was tested. Scans alternate between a stream that is always valid and one that stalls. Some scans receive a spurious start mid-scan. The number of bytes accepted is compared against the value computed from the count, parity and stop point.

// File: rtl/tag_scan_pkg.sv
package tag_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_TEST  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/tag_xor_unit.sv
module tag_xor_unit #(
  parameter int TAG_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [TAG_W-1:0]   ref_i,
  input  logic               capture_i,
  input  logic [2*TAG_W-1:0] byte_i,
  output logic [1:0]         nib_mis_o
);
  localparam int BYTE_W = 2 * TAG_W;

  logic [TAG_W-1:0]  ref_q;
  logic [BYTE_W-1:0] diff_q;
  logic [BYTE_W-1:0] ref_rep;

  assign ref_rep = {2{ref_q}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      diff_q <= '0;
    end else begin
      if (load_i)    ref_q  <= ref_i;
      if (capture_i) diff_q <= byte_i ^ ref_rep;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_nib
    assign nib_mis_o[g] = |diff_q[g*TAG_W +: TAG_W];
  end
endmodule

// File: rtl/tag_match_counter.sv
module tag_match_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             at_last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt   = {1'b0, cnt_q} + 1'b1;
  assign at_last_o = (cnt_nxt == {1'b0, limit_q});
  assign cnt_o     = cnt_q;
  assign limit_o   = limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (load_i) begin
      cnt_q   <= '0;
      limit_q <= limit_i;
    end else if (inc_i) begin
      cnt_q   <= cnt_nxt[CNT_W-1:0];
    end
  end

  // R5: never counts past the requested limit
  a_r5_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q < limit_q));
endmodule

// File: rtl/tag_scan_ctrl.sv
module tag_scan_ctrl
  import tag_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       count_zero_i,
  input  logic       odd_i,
  input  logic       byte_valid_i,
  input  logic [1:0] nib_mis_i,
  input  logic       at_last_i,
  output logic       load_o,
  output logic       capture_o,
  output logic       inc_o,
  output logic       byte_ready_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       pass_o
);
  scan_state_e state_q, state_d;
  logic nib_sel_q, nib_sel_d;
  logic odd_first_q, odd_first_d;
  logic done_q, done_d;
  logic pass_q, pass_d;
  logic cur_mis;

  assign cur_mis      = nib_sel_q ? nib_mis_i[1] : nib_mis_i[0];
  assign byte_ready_o = (state_q == ST_FETCH);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign pass_o       = pass_q;

  always_comb begin
    state_d     = state_q;
    nib_sel_d   = nib_sel_q;
    odd_first_d = odd_first_q;
    done_d      = 1'b0;
    pass_d      = pass_q;
    load_o      = 1'b0;
    capture_o   = 1'b0;
    inc_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          if (count_zero_i) begin
            done_d = 1'b1;
            pass_d = 1'b1;
          end else begin
            odd_first_d = odd_i;
            state_d     = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (byte_valid_i) begin
          capture_o   = 1'b1;
          nib_sel_d   = odd_first_q;
          odd_first_d = 1'b0;
          state_d     = ST_TEST;
        end
      end
      ST_TEST: begin
        if (cur_mis) begin
          done_d  = 1'b1;
          pass_d  = 1'b0;
          state_d = ST_IDLE;
        end else begin
          inc_o = 1'b1;
          if (at_last_i) begin
            done_d  = 1'b1;
            pass_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (nib_sel_q) begin
            state_d = ST_FETCH;
          end else begin
            nib_sel_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      nib_sel_q   <= 1'b0;
      odd_first_q <= 1'b0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      nib_sel_q   <= nib_sel_d;
      odd_first_q <= odd_first_d;
      done_q      <= done_d;
      pass_q      <= pass_d;
    end
  end

  // R9: done lasts one cycle unless a new zero-count scan is started at once
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
  // R8: no byte taken outside a fetch
  a_r8_capture_in_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> (state_q == ST_TEST));
endmodule

// File: rtl/nibble_tag_scan.sv
module nibble_tag_scan #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [TAG_W-1:0]   ref_tag_i,
  input  logic               odd_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [2*TAG_W-1:0] byte_i,
  input  logic               byte_valid_i,
  output logic               byte_ready_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   match_cnt_o,
  output logic               pass_o
);
  logic       load;
  logic       capture;
  logic       inc;
  logic       at_last;
  logic [1:0] nib_mis;
  logic [CNT_W-1:0] limit_q;
  logic       count_zero;

  assign count_zero = (count_i == '0);

  tag_xor_unit #(.TAG_W(TAG_W)) i_xor (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .ref_i     (ref_tag_i),
    .capture_i (capture),
    .byte_i    (byte_i),
    .nib_mis_o (nib_mis)
  );

  tag_match_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .limit_i   (count_i),
    .inc_i     (inc),
    .cnt_o     (match_cnt_o),
    .limit_o   (limit_q),
    .at_last_o (at_last)
  );

  tag_scan_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .count_zero_i (count_zero),
    .odd_i        (odd_i),
    .byte_valid_i (byte_valid_i),
    .nib_mis_i    (nib_mis),
    .at_last_i    (at_last),
    .load_o       (load),
    .capture_o    (capture),
    .inc_o        (inc),
    .byte_ready_o (byte_ready_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pass_o       (pass_o)
  );

  // R6: pass flag agrees with count versus limit
  a_r6_pass_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o == (match_cnt_o == limit_q)));
  // R7: zero-count request completes next cycle
  a_r7_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && count_zero) |=> (done_o && pass_o && match_cnt_o == '0));
  // R8: stream released when the scan ends
  a_r8_ready_low_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_ready_o);
  // R10: start during a scan leaves its limit untouched
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(limit_q));
endmodule

// File: tb/test_nibble_tag_scan.sv
module test_nibble_tag_scan;
  localparam int TAG_W = 4;
  localparam int CNT_W = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] ref_tag_i = '0;
  logic       odd_i = 1'b0;
  logic [3:0] count_i = '0;
  logic [7:0] byte_i = '0;
  logic       byte_valid_i = 1'b0;
  logic       byte_ready_o;
  logic       busy_o;
  logic       done_o;
  logic [3:0] match_cnt_o;
  logic       pass_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] mem [0:11];

  always #2.5 clk_i = ~clk_i;

  nibble_tag_scan #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_nibble_tag_scan (
    .clk_i, .rst_ni, .start_i, .ref_tag_i, .odd_i, .count_i, .byte_i,
    .byte_valid_i, .byte_ready_o, .busy_o, .done_o, .match_cnt_o, .pass_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mm: nibble index (relative to start) of mismatch; mm >= cnt means none in range
  task automatic build_mem(input logic [3:0] rf, input bit odd, input int cnt, input int mm);
    for (int b = 0; b < 12; b++) begin
      logic [3:0] nib [2];
      for (int h = 0; h < 2; h++) begin
        int i = 2*b + h;
        nib[h] = rf;
        if (odd && i == 0) nib[h] = rf ^ 4'hF;
        if (mm < cnt && i == odd + mm) nib[h] = rf ^ (4'h1 << (i % 4));
        if (i == odd + cnt) nib[h] = rf ^ 4'h8;
      end
      mem[b] = {nib[1], nib[0]};
    end
  endtask

  task automatic run_scan(input logic [3:0] rf, input bit odd, input int cnt,
                          input int mm, input bit stall, input bit inject, input string tag);
    int idx = 0;
    bit hs = 1'b0;
    bit got_done = 1'b0;
    int tested, exp_n, exp_bytes;
    tested    = (mm < cnt) ? mm + 1 : cnt;
    exp_n     = (mm < cnt) ? mm : cnt;
    exp_bytes = (cnt == 0) ? 0 : (int'(odd) + tested - 1) / 2 + 1;
    @(negedge clk_i);
    start_i = 1'b1; ref_tag_i = rf; odd_i = odd; count_i = cnt[3:0];
    byte_valid_i = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk_i);
      if (hs) idx++;
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) begin got_done = 1'b1; break; end
      byte_i = (idx < 12) ? mem[idx] : 8'h00;
      byte_valid_i = stall ? ((k % 3) != 1) : 1'b1;
      if (inject && k == 2 && busy_o) begin
        start_i = 1'b1; count_i = ~cnt[3:0]; odd_i = ~odd; ref_tag_i = ~rf;
      end
      #0.5;
      hs = byte_valid_i && byte_ready_o;
    end
    byte_valid_i = 1'b0;
    check({tag, " done seen"}, got_done, 1);
    check({tag, " match count (R3/R5)"}, match_cnt_o, exp_n);
    check({tag, " pass (R6)"}, pass_o, (exp_n == cnt) ? 1 : 0);
    check({tag, " bytes fetched (R8)"}, idx, exp_bytes);
    check({tag, " ready low at done (R8)"}, byte_ready_o, 0);
    @(negedge clk_i);
    check({tag, " done single pulse (R9)"}, done_o, 0);
  endtask

  initial begin
    #1;
    check("R1 busy at reset", busy_o, 0);
    check("R1 ready at reset", byte_ready_o, 0);
    check("R1 done at reset", done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 busy after reset", busy_o, 0);

    // R2: lower nibble tested first
    mem[0] = 8'h75; mem[1] = 8'h55;
    run_scan(4'h5, 1'b0, 2, 1, 1'b0, 1'b0, "R2 upper mismatch");
    mem[0] = 8'h57;
    run_scan(4'h5, 1'b0, 2, 0, 1'b0, 1'b0, "R2 lower mismatch");
    // R7: zero count
    build_mem(4'hA, 1'b0, 0, 16);
    run_scan(4'hA, 1'b0, 0, 16, 1'b0, 1'b0, "R7 zero count");

    // Sweep: R3 R4 R5 R10 R11
    for (int odd = 0; odd < 2; odd++)
      for (int cnt = 0; cnt < 16; cnt++)
        for (int mm = 0; mm <= cnt; mm++) begin
          logic [3:0] rf = 4'((cnt * 7 + mm * 3 + odd * 5) % 16);
          bit stall  = ((cnt + mm) % 2) == 1;
          bit inject = (mm % 3) == 2;
          build_mem(rf, odd[0], cnt, mm);
          run_scan(rf, odd[0], cnt, mm, stall, inject, "sweep R3 R4 R5 R10 R11");
        end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule